// File: doc/BRIEF.md
# Bus Fault Confinement Counter Unit

This unit tracks how trustworthy a node on a shared serial bus currently is. It holds two error counters, one for the node's transmissions and one for its receptions, and derives from them a confinement state: error-active, error-passive or bus-off. The protocol engine that detects errors, parses frames and sends flags sits beside it. That engine reports each relevant event as a single-cycle strobe. It also drives three level inputs for the current context: which role the node plays in the frame, whether its last flag was passive, and whether an exception applies to a transmit flag.

Penalties are asymmetric. Most faults cost eight counts, while each clean frame earns back only one. The unit also counts runs of dominant bits that follow an error or overload flag and charges extra penalties for long runs. A node whose transmit counter reaches the bus-off level stops reacting to every event. It rejoins only after the bus has shown 128 runs of 11 recessive bits, and it then restarts with both counters at zero. A warning output flags a heavily disturbed bus well before the passive level is reached.

The strobes are plain control pins with no handshake. The unit accepts every event in the cycle it is presented, so it never applies back-pressure.

Top module: `fault_confine_unit`

## Requirements
- R1: After reset both counters read 0, the state reads error-active (code 0) and the warning is low.
- R2: A receiver error strobe adds 1 to the receive counter. When the strobe for a bit error during the node's own active or overload flag is high in the same cycle, the plain receiver error adds nothing and only the 8 from that bit-error strobe is applied.
- R3: A transmit error flag strobe adds 8 to the transmit counter. When the exemption level is high in that cycle, the strobe leaves the transmit counter unchanged. The exemption covers a passive-flag acknowledge error and a stuff error during arbitration.
- R4: A bit error during the node's own active or overload flag adds 8 to the transmit counter for a transmitter and to the receive counter for a receiver. A dominant first bit after a receiver's flag adds 8 to the receive counter.
- R5: A successful transmission lowers the transmit counter by 1. A counter already at 0 stays at 0.
- R6: A successful reception lowers the receive counter by 1 when it is between 1 and 127. A counter at 0 stays at 0. A counter of 128 or more is reloaded to 119.
- R7: Increments to the receive counter saturate at 128. The receive counter never exceeds 128.
- R8: The state is encoded as follows: 0 is error-active, 1 is error-passive and 2 is bus-off. The state is bus-off when the transmit counter is 256 or more. Otherwise it is error-passive when either counter is 128 or more. Otherwise it is error-active.
- R9: Each dominant-bit strobe after a flag extends a run, and the run-clear strobe restarts it. A penalty of 8 is charged on the 14th bit of a run when the flag-passive level is low, or on the 8th bit when it is high, and again after every further 8 bits. The role level selects the counter that is charged: high for transmit, low for receive.
- R10: While bus-off, every strobe except the recessive-run strobe is ignored and both counters hold their values. The 128th recessive-run strobe seen while bus-off clears both counters to 0 and returns the state to error-active. Recessive-run strobes have no effect outside bus-off.
- R11: The warning output is high exactly when either counter exceeds 96.
- R12: All increments presented in one cycle are summed. When any increment applies to a counter, a success strobe for that same counter has no effect in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rx_err_i | input | 1 | Receiver detected an error |
| rx_flag_berr_i | input | 1 | Bit error while a receiver sent its active or overload flag |
| rx_dom_first_i | input | 1 | Dominant bit seen as first bit after a receiver's flag |
| tx_flag_i | input | 1 | Transmitter sends an error flag |
| tx_exempt_i | input | 1 | Level: the current transmit flag is exempt from penalty |
| tx_flag_berr_i | input | 1 | Bit error while a transmitter sent its active or overload flag |
| dom_bit_i | input | 1 | One dominant bit sampled after a flag |
| flag_passive_i | input | 1 | Level: the last flag was a passive flag |
| role_tx_i | input | 1 | Level: the node is the transmitter of the current frame |
| run_clear_i | input | 1 | Restart the dominant-run count |
| tx_ok_i | input | 1 | Successful transmission |
| rx_ok_i | input | 1 | Successful reception |
| rec11_i | input | 1 | One run of 11 recessive bits seen |
| state_o | output | 2 | Confinement state (0 active, 1 passive, 2 bus-off) |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| warn_o | output | 1 | Either counter above 96 |

## Verification
Every output is a direct function of the registered counters, so a wrong counter value shows up on tec_o or rec_o at the very next sample after the faulty strobe. The same fault also reaches state_o and warn_o whenever it crosses the 96, 128 or 256 thresholds. The two hidden counts behave differently. A wrong dominant-run count appears only as a penalty landing on the wrong bit of a long run. A wrong recovery count appears only as a bus-off exit on a strobe other than the 128th. The bench therefore checks every output after every cycle against its own model, and drives long runs and complete recovery sequences so that these hidden counts reach the ports.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_PASSIVE = 2'd1,
    ST_BUSOFF  = 2'd2
  } conf_state_e;
endpackage

// File: rtl/fcu_dom_run.sv
// Counts dominant bits after a flag and emits a penalty pulse at the threshold.
module fcu_dom_run #(
  parameter int ACT_RUN  = 14,
  parameter int PAS_RUN  = 8,
  parameter int RUN_STEP = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic clear_i,
  input  logic dom_i,
  input  logic passive_i,
  output logic pen_o
);
  localparam int RW = $clog2(ACT_RUN + 1);
  localparam logic [RW:0]   THR_A   = (RW+1)'(ACT_RUN);
  localparam logic [RW:0]   THR_P   = (RW+1)'(PAS_RUN);
  localparam logic [RW:0]   STEP    = (RW+1)'(RUN_STEP);
  localparam logic [RW-1:0] RUN_MAX = RW'(ACT_RUN - 1);

  logic [RW-1:0] run_q;
  logic [RW:0]   nxt, thr;

  always_comb begin
    nxt   = {1'b0, run_q} + (RW+1)'(1);
    thr   = passive_i ? THR_P : THR_A;
    pen_o = dom_i && !clear_i && !hold_i && (nxt >= thr);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                run_q <= '0;
    else if (hold_i || clear_i) run_q <= '0;
    else if (dom_i)             run_q <= pen_o ? RW'(nxt - STEP) : RW'(nxt);
  end

  // R9: the run never reaches the active threshold without wrapping
  assert_run_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_MAX) else $error("run count out of range");
endmodule

// File: rtl/fcu_tx_counter.sv
// Transmit error counter.
module fcu_tx_counter #(
  parameter int TEC_W   = 9,
  parameter int PENALTY = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             freeze_i,
  input  logic             clear_i,
  input  logic             flag_i,
  input  logic             exempt_i,
  input  logic             berr_i,
  input  logic             pen_i,
  input  logic             ok_i,
  output logic [TEC_W-1:0] tec_o
);
  localparam logic [TEC_W-1:0] PEN_T = TEC_W'(PENALTY);

  logic [TEC_W-1:0] tec_q, inc;

  always_comb begin
    inc = '0;
    if (flag_i && !exempt_i) inc = inc + PEN_T;
    if (berr_i)              inc = inc + PEN_T;
    if (pen_i)               inc = inc + PEN_T;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clear_i) tec_q <= '0;
    else if (!freeze_i) begin
      if (inc != '0)                  tec_q <= tec_q + inc;
      else if (ok_i && tec_q != '0)   tec_q <= tec_q - TEC_W'(1);
    end
  end

  assign tec_o = tec_q;

  // R5: success at zero keeps zero
  assert_tx_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_i && !flag_i && !berr_i && !pen_i && !freeze_i && !clear_i && tec_q == '0)
    |=> tec_q == '0) else $error("transmit counter underflow");
  // R3: an exempt flag alone does not move the counter
  assert_tx_exempt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && exempt_i && !berr_i && !pen_i && !ok_i && !clear_i)
    |=> $stable(tec_q)) else $error("exempt flag changed counter");
endmodule

// File: rtl/fcu_rx_counter.sv
// Receive error counter with saturation at the passive level.
module fcu_rx_counter #(
  parameter int REC_W       = 8,
  parameter int PENALTY     = 8,
  parameter int PASSIVE_LVL = 128,
  parameter int RX_RELOAD   = 119
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             freeze_i,
  input  logic             clear_i,
  input  logic             err_i,
  input  logic             berr_i,
  input  logic             dom_first_i,
  input  logic             pen_i,
  input  logic             ok_i,
  output logic [REC_W-1:0] rec_o
);
  localparam logic [REC_W:0]   PEN_R  = (REC_W+1)'(PENALTY);
  localparam logic [REC_W:0]   CAP    = (REC_W+1)'(PASSIVE_LVL);
  localparam logic [REC_W-1:0] PAS    = REC_W'(PASSIVE_LVL);
  localparam logic [REC_W-1:0] RELOAD = REC_W'(RX_RELOAD);

  logic [REC_W-1:0] rec_q;
  logic [REC_W:0]   inc, sum;

  always_comb begin
    inc = '0;
    if (err_i && !berr_i) inc = inc + (REC_W+1)'(1);
    if (berr_i)           inc = inc + PEN_R;
    if (dom_first_i)      inc = inc + PEN_R;
    if (pen_i)            inc = inc + PEN_R;
    sum = {1'b0, rec_q} + inc;
    if (sum > CAP) sum = CAP;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clear_i) rec_q <= '0;
    else if (!freeze_i) begin
      if (inc != '0)               rec_q <= REC_W'(sum);
      else if (ok_i) begin
        if (rec_q >= PAS)          rec_q <= RELOAD;
        else if (rec_q != '0)      rec_q <= rec_q - REC_W'(1);
      end
    end
  end

  assign rec_o = rec_q;

  // R7: never above the passive level
  assert_rec_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_q <= PAS) else $error("receive counter above cap");
  // R6: success while passive reloads the counter
  assert_rx_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_i && inc == '0 && !freeze_i && !clear_i && rec_q >= PAS)
    |=> rec_q == RELOAD) else $error("receive reload missed");
endmodule

// File: rtl/fcu_busoff_recover.sv
// Counts recessive runs while bus-off and signals when recovery is complete.
module fcu_busoff_recover #(
  parameter int RECOV_RUNS = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busoff_i,
  input  logic rec11_i,
  output logic done_o
);
  localparam int CW = $clog2(RECOV_RUNS + 1);
  localparam logic [CW-1:0] LAST = CW'(RECOV_RUNS - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = busoff_i && rec11_i && (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !busoff_i) cnt_q <= '0;
    else if (rec11_i)         cnt_q <= done_o ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/fault_confine_unit.sv
module fault_confine_unit
  import fcu_pkg::*;
#(
  parameter int TEC_W       = 9,
  parameter int REC_W       = 8,
  parameter int PENALTY     = 8,
  parameter int PASSIVE_LVL = 128,
  parameter int BUSOFF_LVL  = 256,
  parameter int WARN_LVL    = 96,
  parameter int RX_RELOAD   = 119,
  parameter int RECOV_RUNS  = 128,
  parameter int ACT_RUN     = 14,
  parameter int PAS_RUN     = 8,
  parameter int RUN_STEP    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_err_i,
  input  logic             rx_flag_berr_i,
  input  logic             rx_dom_first_i,
  input  logic             tx_flag_i,
  input  logic             tx_exempt_i,
  input  logic             tx_flag_berr_i,
  input  logic             dom_bit_i,
  input  logic             flag_passive_i,
  input  logic             role_tx_i,
  input  logic             run_clear_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic             rec11_i,
  output logic [1:0]       state_o,
  output logic [TEC_W-1:0] tec_o,
  output logic [REC_W-1:0] rec_o,
  output logic             warn_o
);
  localparam logic [TEC_W-1:0] TEC_OFF  = TEC_W'(BUSOFF_LVL);
  localparam logic [TEC_W-1:0] TEC_PAS  = TEC_W'(PASSIVE_LVL);
  localparam logic [REC_W-1:0] REC_PAS  = REC_W'(PASSIVE_LVL);
  localparam logic [TEC_W-1:0] TEC_WARN = TEC_W'(WARN_LVL);
  localparam logic [REC_W-1:0] REC_WARN = REC_W'(WARN_LVL);

  logic        busoff, pen, done;
  conf_state_e st;

  assign busoff = (tec_o >= TEC_OFF);

  fcu_dom_run #(.ACT_RUN(ACT_RUN), .PAS_RUN(PAS_RUN), .RUN_STEP(RUN_STEP)) u_run (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(busoff), .clear_i(run_clear_i),
    .dom_i(dom_bit_i), .passive_i(flag_passive_i), .pen_o(pen));

  fcu_tx_counter #(.TEC_W(TEC_W), .PENALTY(PENALTY)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .freeze_i(busoff), .clear_i(done),
    .flag_i(tx_flag_i), .exempt_i(tx_exempt_i), .berr_i(tx_flag_berr_i),
    .pen_i(pen && role_tx_i), .ok_i(tx_ok_i), .tec_o(tec_o));

  fcu_rx_counter #(.REC_W(REC_W), .PENALTY(PENALTY), .PASSIVE_LVL(PASSIVE_LVL),
                   .RX_RELOAD(RX_RELOAD)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .freeze_i(busoff), .clear_i(done),
    .err_i(rx_err_i), .berr_i(rx_flag_berr_i), .dom_first_i(rx_dom_first_i),
    .pen_i(pen && !role_tx_i), .ok_i(rx_ok_i), .rec_o(rec_o));

  fcu_busoff_recover #(.RECOV_RUNS(RECOV_RUNS)) u_recov (
    .clk_i(clk_i), .rst_ni(rst_ni), .busoff_i(busoff), .rec11_i(rec11_i), .done_o(done));

  always_comb begin
    if (busoff)                                   st = ST_BUSOFF;
    else if (tec_o >= TEC_PAS || rec_o >= REC_PAS) st = ST_PASSIVE;
    else                                          st = ST_ACTIVE;
  end

  assign state_o = st;
  assign warn_o  = (tec_o > TEC_WARN) || (rec_o > REC_WARN);

  // R10: counters frozen in bus-off until recovery completes
  assert_busoff_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_BUSOFF && !done) |=> ($stable(tec_o) && $stable(rec_o)))
    else $error("counter moved while bus-off");
  // R10: recovery clears both counters
  assert_recover_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (tec_o == '0 && rec_o == '0 && st == ST_ACTIVE))
    else $error("recovery did not clear counters");
endmodule

// File: tb/fault_confine_unit_bench.sv
`timescale 1ns/1ps
module fault_confine_unit_bench;
  localparam int E_RXERR = 0, E_RXBERR = 1, E_RXDOM = 2, E_TXFLAG = 3, E_TXEX = 4,
                 E_TXBERR = 5, E_DOM = 6, E_FPAS = 7, E_ROLE = 8, E_RCLR = 9,
                 E_TXOK = 10, E_RXOK = 11, E_R11 = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [12:0] ev;
  logic [1:0]  state;
  logic [8:0]  tec;
  logic [7:0]  rec;
  logic        warn;

  fault_confine_unit u_fault_confine_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_err_i(ev[E_RXERR]), .rx_flag_berr_i(ev[E_RXBERR]), .rx_dom_first_i(ev[E_RXDOM]),
    .tx_flag_i(ev[E_TXFLAG]), .tx_exempt_i(ev[E_TXEX]), .tx_flag_berr_i(ev[E_TXBERR]),
    .dom_bit_i(ev[E_DOM]), .flag_passive_i(ev[E_FPAS]), .role_tx_i(ev[E_ROLE]),
    .run_clear_i(ev[E_RCLR]), .tx_ok_i(ev[E_TXOK]), .rx_ok_i(ev[E_RXOK]),
    .rec11_i(ev[E_R11]), .state_o(state), .tec_o(tec), .rec_o(rec), .warn_o(warn));

  int  m_tec, m_rec, m_run, m_rcv;
  int  n_chk, n_fail;
  bit  finished;

  function automatic logic [12:0] b(input int i);
    return 13'(1) << i;
  endfunction

  task automatic model_step(input logic [12:0] e);
    int inc_t, inc_r, thr;
    bit pen;
    if (m_tec >= 256) begin
      m_run = 0;
      if (e[E_R11]) begin
        m_rcv++;
        if (m_rcv == 128) begin m_tec = 0; m_rec = 0; m_rcv = 0; end
      end
      return;
    end
    m_rcv = 0;
    pen = 0;
    if (e[E_RCLR]) m_run = 0;
    else if (e[E_DOM]) begin
      thr = e[E_FPAS] ? 8 : 14;
      if (m_run + 1 >= thr) begin pen = 1; m_run = m_run + 1 - 8; end
      else m_run++;
    end
    inc_t = 0; inc_r = 0;
    if (e[E_TXFLAG] && !e[E_TXEX]) inc_t += 8;
    if (e[E_TXBERR]) inc_t += 8;
    if (pen && e[E_ROLE]) inc_t += 8;
    if (e[E_RXERR] && !e[E_RXBERR]) inc_r += 1;
    if (e[E_RXBERR]) inc_r += 8;
    if (e[E_RXDOM]) inc_r += 8;
    if (pen && !e[E_ROLE]) inc_r += 8;
    if (inc_t != 0) m_tec += inc_t;
    else if (e[E_TXOK] && m_tec > 0) m_tec--;
    if (inc_r != 0) m_rec = (m_rec + inc_r > 128) ? 128 : m_rec + inc_r;
    else if (e[E_RXOK]) begin
      if (m_rec >= 128) m_rec = 119;
      else if (m_rec > 0) m_rec--;
    end
  endtask

  task automatic compare(input string tag);
    int es; bit ew;
    es = (m_tec >= 256) ? 2 : ((m_tec >= 128 || m_rec >= 128) ? 1 : 0);
    ew = (m_tec > 96) || (m_rec > 96);
    n_chk++;
    if (int'(tec) != m_tec || int'(rec) != m_rec || int'(state) != es || warn != ew) begin
      n_fail++;
      $display("FAIL %s: tec=%0d rec=%0d state=%0d warn=%0d expected tec=%0d rec=%0d state=%0d warn=%0d",
               tag, tec, rec, state, warn, m_tec, m_rec, es, ew);
    end
  endtask

  task automatic chk_val(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [12:0] e, input string tag);
    ev = e;
    @(posedge clk);
    model_step(e);
    @(negedge clk);
    ev = '0;
    compare(tag);
  endtask

  function automatic bit pr(input int pct);
    return $urandom_range(99, 0) < pct;
  endfunction

  task automatic random_phase(input int n, input int p_err, input int p_ok, input int p_r11);
    logic [12:0] e;
    for (int i = 0; i < n; i++) begin
      e = '0;
      e[E_RXERR]  = pr(p_err);  e[E_RXBERR] = pr(p_err / 3);
      e[E_RXDOM]  = pr(p_err / 3); e[E_TXFLAG] = pr(p_err);
      e[E_TXEX]   = pr(30);     e[E_TXBERR] = pr(p_err / 3);
      e[E_DOM]    = pr(40);     e[E_FPAS]   = pr(50);
      e[E_ROLE]   = pr(50);     e[E_RCLR]   = pr(5);
      e[E_TXOK]   = pr(p_ok);   e[E_RXOK]   = pr(p_ok);
      e[E_R11]    = pr(p_r11);
      apply(e, "R8/R11/R12 random");
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_tec = 0; m_rec = 0; m_run = 0; m_rcv = 0;
    n_chk = 0; n_fail = 0;
    ev = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 reset");
    chk_val("R1 reset warn", int'(warn), 0);

    // R2: plain receiver errors and the flag bit-error exception
    repeat (3) apply(b(E_RXERR), "R2 rx error");
    chk_val("R2 rec after 3 errors", int'(rec), 3);
    apply(b(E_RXERR) | b(E_RXBERR), "R2 exception");
    chk_val("R2 rec after exception", int'(rec), 11);
    // R4
    apply(b(E_RXDOM), "R4 dominant after flag");
    apply(b(E_TXBERR), "R4 tx flag bit error");
    // R3
    apply(b(E_TXFLAG), "R3 tx flag");
    apply(b(E_TXFLAG) | b(E_TXEX), "R3 exempt flag");
    chk_val("R3 tec after exempt", int'(tec), 16);
    // R12
    apply(b(E_TXFLAG) | b(E_TXOK), "R12 increment beats success");
    apply(b(E_TXFLAG) | b(E_TXBERR), "R12 summed increments");
    chk_val("R12 tec", int'(tec), 40);
    // R5: drain to zero and past it
    repeat (45) apply(b(E_TXOK), "R5 success decrement");
    chk_val("R5 floor", int'(tec), 0);
    // R6: small decrements and zero floor
    repeat (25) apply(b(E_RXOK), "R6 rx success");
    chk_val("R6 floor", int'(rec), 0);

    // R9: active run charged to transmitter on the 14th bit then every 8
    repeat (13) apply(b(E_DOM) | b(E_ROLE), "R9 run below threshold");
    chk_val("R9 no penalty before 14th", int'(tec), 0);
    apply(b(E_DOM) | b(E_ROLE), "R9 14th bit");
    chk_val("R9 penalty at 14th", int'(tec), 8);
    repeat (8) apply(b(E_DOM) | b(E_ROLE), "R9 further run");
    chk_val("R9 penalty after 8 more", int'(tec), 16);
    apply(b(E_RCLR), "R9 clear");
    repeat (8) apply(b(E_DOM) | b(E_FPAS), "R9 passive run to receiver");
    chk_val("R9 passive penalty", int'(rec), 8);

    // R7 and R8: saturate receive counter, go passive, reload
    repeat (16) apply(b(E_RXBERR), "R7 saturation");
    chk_val("R7 cap", int'(rec), 128);
    chk_val("R8 passive", int'(state), 1);
    apply(b(E_RXOK), "R6 reload");
    chk_val("R6 reload value", int'(rec), 119);
    chk_val("R8 back to active", int'(state), 0);

    // R10: reach bus-off, ignore events, recover after 128 runs
    repeat (4) apply(b(E_R11), "R10 ignored outside bus-off");
    repeat (30) apply(b(E_TXFLAG), "R8 toward bus-off");
    chk_val("R8 bus-off", int'(state), 2);
    apply(b(E_RXERR) | b(E_TXOK) | b(E_RXOK) | b(E_TXFLAG), "R10 ignored in bus-off");
    repeat (127) apply(b(E_R11), "R10 recovery count");
    chk_val("R10 still bus-off", int'(state), 2);
    apply(b(E_R11), "R10 128th run");
    chk_val("R10 active after recovery", int'(state), 0);
    chk_val("R10 tec cleared", int'(tec), 0);

    // Random phases
    random_phase(4000, 5, 40, 5);
    random_phase(4000, 50, 10, 60);
    random_phase(4000, 20, 20, 20);

    finished = 1;
    summary();
    $finish;
  end
endmodule